// File: doc/BRIEF.md
# Pixel to FP16 Normalizer

This block is a single pipeline lane that takes one raw pixel of `CH` channel elements per transfer and turns every element into a half-precision (FP16) value. The raw element encoding is fixed at build time by a parameter: unsigned 8-bit, unsigned 16-bit, or FP16 that is carried through as it is. When normalization is built in, each converted value first has a per-channel bias added and is then multiplied by a per-channel scale. Both operations are done in FP16 with round-to-nearest-even. Results that would be subnormal are flushed to a zero of the same sign. Infinities and NaNs follow IEEE rules, and every NaN result takes the single quiet encoding 0x7E00.

A design with several parallel pixels instantiates one lane per pixel. Pixels enter and leave over valid/ready interfaces. The pipeline is three registers deep and moves only when `out_ready` is high. `in_ready` mirrors `out_ready`, so a low `out_ready` freezes every stage, including empty ones. A transfer happens on a clock edge where valid and ready are both high. A producer may hold `in_valid` high for any length of time, and the lane keeps `out_valid` and `out_pix` steady until the consumer takes the word. Bias and scale are runtime registers written through a plain write port addressed by channel.

Top module: `pxn_lane`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0. Reset sets every bias register to +0.0 (0x0000) and every scale register to +1.0 (0x3C00), so with no writes each output equals the converted input.
- R2: With U16 or U8 input, an integer value up to 2048 converts exactly to FP16 (for example 1000 becomes 0x63D0 and 255 becomes 0x5BF8). Channel c sits at `in_pix[c*W +: W]` and at `out_pix[c*16 +: 16]`.
- R3: A U16 value above 2048 is rounded to 11 significant bits, to nearest with ties to even: 2049 becomes 0x6800, 2051 becomes 0x6802 and 4095 becomes 0x6C00.
- R4: A U16 value that rounds past the largest finite FP16 value saturates to 0x7BFF. This applies to 65504, 65520 and 65535.
- R5: With normalization built in, each channel outputs (x + bias) * scale. Each operation is rounded separately to nearest-even, for example 2048 + 3.0 gives 0x6802 and 3 * 0x3C01 gives 0x4202.
- R6: A write with `cfg_we` = 1 loads `cfg_data` into the bias register (`cfg_kind` = 0) or the scale register (`cfg_kind` = 1) of channel `cfg_ch` only. A write whose channel index is CH or more changes nothing.
- R7: A normalization result whose magnitude is below 2^-14 is output as a zero that keeps its sign. No output word from the normalizing path has a zero exponent field and a nonzero fraction. An exact cancellation in the add gives +0.
- R8: When an add or a multiply overflows, the result is an infinity of the correct sign. A NaN operand, inf * 0 and inf + (-inf) each give 0x7E00. An infinite operand otherwise propagates.
- R9: A pixel accepted in cycle n appears on the output in cycle n+3 when `out_ready` stays high. `in_ready` equals `out_ready`. While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_pix` hold, and no more than 3 pixels are ever in flight.
- R10: With FP16 input and normalization not built in, every output word equals its input word bit for bit, including subnormals, signed zeros and NaN payloads. Bias and scale writes then have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Lane can take a pixel (mirrors out_ready) |
| in_pix | input | CH*W | Raw pixel, W = 8 for U8 and 16 otherwise, channel 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | CH*16 | FP16 pixel, channel 0 in the low bits |
| cfg_we | input | 1 | Bias/scale register write strobe |
| cfg_kind | input | 1 | 0 selects the bias register, 1 selects the scale register |
| cfg_ch | input | max(1,$clog2(CH)) | Channel index of the write |
| cfg_data | input | 16 | FP16 value to store |

## Verification
The bench builds two lanes. The first has three channels, U16 input and normalization built in. U16 is the only input type that exercises integer rounding ties, mantissa carry-out and saturation. With three channels the 2-bit channel address has one unused value (3), which is needed to show that an out-of-range write is ignored. The second lane has two channels, FP16 input and no normalization. It shows the bypass path carrying subnormals and NaN payloads bit for bit, and shows that bias and scale writes have no effect there.

// File: rtl/pxn_pkg.sv
package pxn_pkg;

  typedef enum logic [1:0] {FMT_U8, FMT_U16, FMT_F16} pxn_fmt_e;

  localparam logic [15:0] HALF_QNAN = 16'h7E00;
  localparam logic [15:0] HALF_MAXF = 16'h7BFF;
  localparam logic [15:0] HALF_ONE  = 16'h3C00;

  // value represented = mag * 2^lsb_exp; rounds to 11 significant bits (RNE)
  function automatic logic [15:0] half_pack(input logic sgn, input logic [31:0] mag,
                                            input int lsb_exp, input logic sat);
    int msb;
    int bexp;
    logic [31:0] keep;
    logic [31:0] mask;
    logic guard;
    logic sticky;
    msb = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) msb = i;
    if (mag == 32'd0) return {sgn, 15'h0};
    bexp = msb + lsb_exp + 15;
    if (msb > 10) begin
      keep   = mag >> (msb - 10);
      guard  = mag[msb - 11];
      mask   = (32'd1 << (msb - 11)) - 32'd1;
      sticky = |(mag & mask);
      if (guard && (sticky || keep[0])) keep = keep + 32'd1;
      if (keep[11]) begin
        keep = keep >> 1;
        bexp = bexp + 1;
      end
    end else begin
      keep = mag << (10 - msb);
    end
    if (bexp <= 0) return {sgn, 15'h0};
    if (bexp >= 31) return sat ? {sgn, HALF_MAXF[14:0]} : {sgn, 5'h1F, 10'h0};
    return {sgn, bexp[4:0], keep[9:0]};
  endfunction

  function automatic logic [15:0] half_from_uint(input logic [15:0] v);
    return half_pack(1'b0, {16'h0, v}, 0, 1'b1);
  endfunction

  function automatic logic [15:0] half_add(input logic [15:0] a, input logic [15:0] b);
    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic [15:0] x, y;
    logic [23:0] mx, my, lost;
    logic [24:0] sum;
    int d;
    a_nan  = (&a[14:10]) && (|a[9:0]);
    b_nan  = (&b[14:10]) && (|b[9:0]);
    a_inf  = (&a[14:10]) && !(|a[9:0]);
    b_inf  = (&b[14:10]) && !(|b[9:0]);
    a_zero = (a[14:10] == 5'd0);
    b_zero = (b[14:10] == 5'd0);
    if (a_nan || b_nan) return HALF_QNAN;
    if (a_inf && b_inf) return (a[15] == b[15]) ? a : HALF_QNAN;
    if (a_inf) return a;
    if (b_inf) return b;
    if (a_zero && b_zero) return {a[15] & b[15], 15'h0};
    if (a_zero) return b;
    if (b_zero) return a;
    if (b[14:0] > a[14:0]) begin
      x = b; y = a;
    end else begin
      x = a; y = b;
    end
    mx = {1'b1, x[9:0], 13'h0};
    my = {1'b1, y[9:0], 13'h0};
    d  = int'(x[14:10]) - int'(y[14:10]);
    if (d >= 24) begin
      my = 24'd1;
    end else begin
      lost = my & ((24'd1 << d) - 24'd1);
      my   = my >> d;
      my[0] = my[0] | (|lost);
    end
    sum = (x[15] == y[15]) ? ({1'b0, mx} + {1'b0, my}) : ({1'b0, mx} - {1'b0, my});
    if (sum == 25'd0) return 16'h0000;
    return half_pack(x[15], {7'h0, sum}, int'(x[14:10]) - 38, 1'b0);
  endfunction

  function automatic logic [15:0] half_mul(input logic [15:0] a, input logic [15:0] b);
    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, s;
    logic [21:0] prod;
    a_nan  = (&a[14:10]) && (|a[9:0]);
    b_nan  = (&b[14:10]) && (|b[9:0]);
    a_inf  = (&a[14:10]) && !(|a[9:0]);
    b_inf  = (&b[14:10]) && !(|b[9:0]);
    a_zero = (a[14:10] == 5'd0);
    b_zero = (b[14:10] == 5'd0);
    s = a[15] ^ b[15];
    if (a_nan || b_nan) return HALF_QNAN;
    if ((a_inf && b_zero) || (b_inf && a_zero)) return HALF_QNAN;
    if (a_inf || b_inf) return {s, 15'h7C00};
    if (a_zero || b_zero) return {s, 15'h0};
    prod = 22'({1'b1, a[9:0]}) * 22'({1'b1, b[9:0]});
    return half_pack(s, {10'h0, prod}, int'(a[14:10]) + int'(b[14:10]) - 50, 1'b0);
  endfunction

endpackage

// File: rtl/pxn_cvt.sv
module pxn_cvt #(
  parameter pxn_pkg::pxn_fmt_e FMT = pxn_pkg::FMT_U16,
  parameter int IW = 16
) (
  input  logic [IW-1:0] raw,
  output logic [15:0]   half
);
  if (FMT == pxn_pkg::FMT_F16) begin : g_pass
    assign half = 16'(raw);
  end else begin : g_int
    assign half = pxn_pkg::half_from_uint(16'(raw));
  end
endmodule

// File: rtl/pxn_fadd.sv
module pxn_fadd (
  input  logic [15:0] a,
  input  logic [15:0] b,
  output logic [15:0] y
);
  assign y = pxn_pkg::half_add(a, b);
endmodule

// File: rtl/pxn_fmul.sv
module pxn_fmul (
  input  logic [15:0] a,
  input  logic [15:0] b,
  output logic [15:0] y
);
  assign y = pxn_pkg::half_mul(a, b);
endmodule

// File: rtl/pxn_lane.sv
module pxn_lane #(
  parameter int CH = 3,
  parameter pxn_pkg::pxn_fmt_e FMT = pxn_pkg::FMT_U16,
  parameter bit NORM_EN = 1'b1,
  localparam int IW = (FMT == pxn_pkg::FMT_U8) ? 8 : 16,
  localparam int CW = (CH > 1) ? $clog2(CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CH*IW-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CH*16-1:0] out_pix,
  input  logic             cfg_we,
  input  logic             cfg_kind,
  input  logic [CW-1:0]    cfg_ch,
  input  logic [15:0]      cfg_data
);
  localparam bit OUT_FLUSHED = NORM_EN || (FMT != pxn_pkg::FMT_F16);

  logic adv;
  logic v1_q, v2_q, v3_q;

  assign adv       = out_ready;
  assign in_ready  = out_ready;
  assign out_valid = v3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else if (adv) begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [15:0] cvt_w, add_w, mul_w;
    logic [15:0] s1_q, s2_q, s3_q;
    logic [15:0] bias_q, scale_q;

    pxn_cvt #(.FMT(FMT), .IW(IW)) u_cvt (
      .raw  (in_pix[c*IW +: IW]),
      .half (cvt_w)
    );

    if (NORM_EN) begin : g_norm
      pxn_fadd u_add (.a(s1_q), .b(bias_q),  .y(add_w));
      pxn_fmul u_mul (.a(s2_q), .b(scale_q), .y(mul_w));
    end else begin : g_byp
      assign add_w = s1_q;
      assign mul_w = s2_q;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q <= 16'h0;
        s2_q <= 16'h0;
        s3_q <= 16'h0;
      end else if (adv) begin
        s1_q <= cvt_w;
        s2_q <= add_w;
        s3_q <= mul_w;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bias_q  <= 16'h0000;
        scale_q <= pxn_pkg::HALF_ONE;
      end else if (cfg_we && (cfg_ch == CW'(c))) begin
        if (cfg_kind) scale_q <= cfg_data;
        else          bias_q  <= cfg_data;
      end
    end

    assign out_pix[c*16 +: 16] = s3_q;
  end
endmodule

// File: rtl/pxn_lane_chk.sv
module pxn_lane_chk #(
  parameter int CH = 3,
  parameter bit FLUSH_ON = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [CH*16-1:0] out_pix
);
  logic [1:0] since_rst;
  logic [2:0] tok;
  logic       sub_seen;
  logic       in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
      tok       <= 3'd0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
      tok <= tok + 3'(in_fire) - 3'(out_fire);
    end
  end

  always_comb begin
    sub_seen = 1'b0;
    for (int c = 0; c < CH; c++)
      if (out_pix[c*16+10 +: 5] == 5'd0 && out_pix[c*16 +: 10] != 10'd0) sub_seen = 1'b1;
  end

  AST_LATENCY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) && $past(in_fire, 3) && $past(out_ready, 1) && $past(out_ready, 2) |-> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R9
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> tok != 3'd0); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tok <= 3'd3); // R9
  AST_SUB_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    FLUSH_ON && out_valid |-> !sub_seen); // R7
endmodule

bind pxn_lane pxn_lane_chk #(.CH(CH), .FLUSH_ON(OUT_FLUSHED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix)
);

// File: tb/tb_pxn_lane.sv
`timescale 1ns/1ps
module tb_pxn_lane;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [47:0] in_pix, out_pix;
  logic        cfg_we, cfg_kind;
  logic [1:0]  cfg_ch;
  logic [15:0] cfg_data;

  logic        pt_in_valid, pt_in_ready, pt_out_valid, pt_cfg_we, pt_cfg_kind;
  logic [0:0]  pt_cfg_ch;
  logic [31:0] pt_in_pix, pt_out_pix;

  pxn_lane #(.CH(3), .FMT(pxn_pkg::FMT_U16), .NORM_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_ch(cfg_ch), .cfg_data(cfg_data));

  pxn_lane #(.CH(2), .FMT(pxn_pkg::FMT_F16), .NORM_EN(1'b0)) dut_pt (
    .clk(clk), .rst_n(rst_n), .in_valid(pt_in_valid), .in_ready(pt_in_ready), .in_pix(pt_in_pix),
    .out_valid(pt_out_valid), .out_ready(out_ready), .out_pix(pt_out_pix),
    .cfg_we(pt_cfg_we), .cfg_kind(pt_cfg_kind), .cfg_ch(pt_cfg_ch), .cfg_data(cfg_data));

  int n_vec = 0;
  int n_bad = 0;

  // entry: {bias ch2..ch0, scale ch2..ch0, pixel ch2..ch0, expected ch2..ch0}
  localparam int NV = 10;
  localparam logic [191:0] VEC [NV] = '{
    {48'h0000_0000_0000, 48'h3C00_3C00_3C00, {16'd1000, 16'd1, 16'd0},        48'h63D0_3C00_0000},
    {48'h0000_0000_0000, 48'h3C00_3C00_3C00, {16'd4095, 16'd2051, 16'd2049},  48'h6C00_6802_6800},
    {48'h0000_0000_0000, 48'h3C00_3C00_3C00, {16'd65535, 16'd65520, 16'd65504}, 48'h7BFF_7BFF_7BFF},
    {48'h0000_0000_0000, 48'h3C00_3C00_3C00, {16'd255, 16'd3, 16'd2048},      48'h5BF8_4200_6800},
    {48'h3800_0000_BC00, 48'h3C00_4000_3800, {16'd2, 16'd1000, 16'd3},        48'h4100_67D0_3C00},
    {48'hBE00_BC00_B800, 48'h0400_BC00_0400, {16'd1, 16'd1, 16'd1},           48'h8000_8000_0000},
    {48'h7E01_7C00_0000, 48'h3C00_3800_7C00, {16'd5, 16'd5, 16'd0},           48'h7E00_7C00_7E00},
    {48'h0000_4200_3C00, 48'h3C01_3C00_3C00, {16'd3, 16'd2048, 16'd2048},     48'h4202_6802_6800},
    {48'h0000_8000_C200, 48'hBC00_3C00_3400, {16'd100, 16'd0, 16'd1},        48'hD640_0000_B800},
    {48'h7BFF_0000_0000, 48'h3C00_C000_4000, {16'd65535, 16'd65504, 16'd65504}, 48'h7C00_FC00_7C00}
  };
  string vtag [NV] = '{"R2", "R3", "R4", "R2", "R5", "R7", "R8", "R5", "R8", "R8"};

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic kind, input logic [1:0] ch, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_ch = ch; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_px(input logic [47:0] pix, input logic [47:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_pix = pix;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid && out_pix == exp, tag, out_pix, exp);
  endtask

  task automatic run_pt(input logic [31:0] pix, input string tag);
    @(negedge clk);
    pt_in_valid = 1'b1; pt_in_pix = pix;
    @(negedge clk);
    pt_in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pt_out_valid && pt_out_pix == pix, tag, {16'h0, pt_out_pix}, {16'h0, pix});
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_pix = '0; out_ready = 1'b1;
    cfg_we = 1'b0; cfg_kind = 1'b0; cfg_ch = '0; cfg_data = '0;
    pt_in_valid = 1'b0; pt_in_pix = '0; pt_cfg_we = 1'b0; pt_cfg_kind = 1'b0; pt_cfg_ch = '0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R1", {47'h0, out_valid}, 48'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", {46'h0, out_valid, in_ready}, 48'h1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      for (int c = 0; c < 3; c++) begin
        cfg_wr(1'b0, 2'(c), VEC[i][144 + c*16 +: 16]);
        cfg_wr(1'b1, 2'(c), VEC[i][96 + c*16 +: 16]);
      end
      run_px(VEC[i][48 +: 48], VEC[i][0 +: 48], vtag[i]);
    end

    // R1: reset restores bias 0.0 and scale 1.0
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    run_px({16'd7, 16'd6, 16'd5}, 48'h4700_4600_4500, "R1");

    // R6: out-of-range channel write ignored, then one register of channel 1
    cfg_wr(1'b0, 2'd3, 16'h4000);
    cfg_wr(1'b1, 2'd3, 16'h0000);
    run_px({16'd7, 16'd6, 16'd5}, 48'h4700_4600_4500, "R6");
    cfg_wr(1'b1, 2'd1, 16'h4000);
    run_px({16'd7, 16'd6, 16'd5}, 48'h4700_4A00_4500, "R6");

    // R9: exact latency, then a stall with three pixels in flight
    @(negedge clk); in_valid = 1'b1; in_pix = {16'd1, 16'd1, 16'd1};
    @(negedge clk); in_pix = {16'd2, 16'd2, 16'd2};
    @(negedge clk); in_pix = {16'd3, 16'd3, 16'd3};
    check(!out_valid, "R9", {47'h0, out_valid}, 48'h0);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid && out_pix == 48'h3C00_4000_3C00, "R9", out_pix, 48'h3C00_4000_3C00);
    out_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && !in_ready && out_pix == 48'h3C00_4000_3C00, "R9", out_pix, 48'h3C00_4000_3C00);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && out_pix == 48'h4000_4400_4000, "R9", out_pix, 48'h4000_4400_4000);
    @(negedge clk);
    check(out_valid && out_pix == 48'h4200_4600_4200, "R9", out_pix, 48'h4200_4600_4200);
    @(negedge clk);
    check(!out_valid, "R9", {47'h0, out_valid}, 48'h0);

    // R10: bypass lane is bit exact and ignores bias/scale writes
    @(negedge clk);
    pt_cfg_we = 1'b1; pt_cfg_kind = 1'b1; pt_cfg_ch = 1'b0; cfg_data = 16'h0000;
    @(negedge clk);
    pt_cfg_kind = 1'b0; pt_cfg_ch = 1'b1; cfg_data = 16'h7C00;
    @(negedge clk);
    pt_cfg_we = 1'b0;
    run_pt({16'h7D55, 16'h0001}, "R10");
    run_pt({16'h8000, 16'hFBFF}, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule